// File: doc/BRIEF.md
# Half-to-Single Precision Float Widener

This block converts a 16-bit IEEE-754 binary16 operand into the binary32 value of the same number. Every binary16 value can be written exactly in binary32, so the conversion never rounds and needs no rounding-mode input. An operand arrives on a 16-bit input with a valid strobe. The widened 32-bit result and its valid flag appear on registered outputs one clock cycle later.

The datapath first sorts the operand magnitude into one of four kinds: zero, subnormal, normal, or special (infinity or NaN). A normal operand is widened by moving the field into place and re-biasing the exponent. A special operand keeps its whole fraction, including the quiet bit, under an all-ones exponent. A zero stays zero. A subnormal operand has no hidden one, so it is renormalised into a binary32 normal. A leading-zero count over the significand region gives the left shift, and the same count also lowers the exponent. The sign bit is copied across in every case.

Top module: `fpw_half_to_single`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid_o is 0 and out_single_o is 0, whatever in_valid_i carries.
- R2: out_valid_o equals in_valid_i from the previous clock cycle, and a valid operand's result appears on out_single_o exactly one cycle after it is presented.
- R3: When in_valid_i is 0, out_single_o keeps its previous value, whatever in_half_i holds.
- R4: For an operand whose exponent field (bits 14:10) is 1 to 30, the result exponent (bits 30:23) is that field plus 112, and result bits 22:13 equal operand bits 9:0, with bits 12:0 zero.
- R5: An operand magnitude of 0x7C00 (infinity) gives magnitude 0x7F800000.
- R6: An operand with exponent field 31 and a nonzero fraction (NaN) gives exponent 255, with result bits 22:13 equal to operand bits 9:0 (bit 22 being the quiet bit) and bits 12:0 zero.
- R7: For a subnormal operand (exponent field 0, fraction f nonzero), let s be the number of leading zeros of the 11-bit value {1'b0, f}. The result exponent is 113 − s, and result bits 22:13 are the low 10 bits of f shifted left by s.
- R8: An operand magnitude of 0 gives result magnitude 0, so +0 maps to 0x00000000 and −0 maps to 0x80000000.
- R9: Result bit 31 equals operand bit 15 for every operand.
- R10: Each of the 65536 operand encodings gives the binary32 encoding of the same real value, or of a NaN as stated in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operand strobe |
| in_half_i | input | 16 | binary16 operand |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| out_single_o | output | 32 | binary32 result, held while no operand arrives |

## Verification
The subnormal path is the hard one to reach. It must be driven across all ten positions of the leading one, and the two ends are where an off-by-one in the shift or the exponent would show. Directed operands 0x0001, 0x0200 and 0x03FF hit the smallest, largest-scale and densest subnormals. A back-to-back stream of all 65536 encodings then compares each result with a model built from the position of the highest set bit, not from a leading-zero count. That stream also pins down the boundaries between zero, subnormal and normal, and between normal and special, where the wrapping range compare decides the kind.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    // Operand kind chosen by the magnitude classifier
    typedef enum logic [1:0] {
        FK_ZERO = 2'd0,
        FK_SUB  = 2'd1,
        FK_NORM = 2'd2,
        FK_SPEC = 2'd3
    } fkind_e;

    localparam int HALF_EXP_W   = 5;
    localparam int HALF_MAN_W   = 10;
    localparam int SINGLE_EXP_W = 8;
    localparam int SINGLE_MAN_W = 23;

endpackage

// File: rtl/fpw_lzc.sv
// Leading-zero counter, binary search over halves of a power-of-two
// padded word. Valid for nonzero inputs; the padding is ones so an
// all-zero input of a non-power-of-two width yields WIDTH.
module fpw_lzc #(
    parameter int WIDTH = 11
) (
    input  logic [WIDTH-1:0]             val_i,
    output logic [$clog2(WIDTH+1)-1:0]   cnt_o
);
    localparam int LVL  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int PW   = 1 << LVL;
    localparam int PADW = PW - WIDTH;
    localparam int CW   = $clog2(WIDTH+1);

    logic [PW-1:0]  stage [0:LVL];
    logic [LVL-1:0] zhalf;

    generate
        if (PADW > 0) begin : g_pad
            assign stage[LVL] = {val_i, {PADW{1'b1}}};
        end else begin : g_nopad
            assign stage[LVL] = val_i;
        end

        for (genvar k = LVL - 1; k >= 0; k--) begin : g_lvl
            localparam int HALF = 1 << k;
            assign zhalf[k]  = (stage[k+1][PW-1 -: HALF] == '0);
            assign stage[k]  = zhalf[k] ? (stage[k+1] << HALF) : stage[k+1];
        end
    endgenerate

    assign cnt_o = CW'(zhalf);

endmodule

// File: rtl/fpw_classify.sv
// Sorts a sign-less binary16-style magnitude into zero, subnormal,
// normal or special. Normal test uses a wrapping range compare.
module fpw_classify
    import fpw_pkg::*;
#(
    parameter int EXP_W = HALF_EXP_W,
    parameter int MAN_W = HALF_MAN_W
) (
    input  logic [EXP_W+MAN_W-1:0] mag_i,
    output fkind_e                 kind_o
);
    localparam int MW = EXP_W + MAN_W;
    localparam logic [MW:0] MIN_NORM = (MW+1)'(1) << MAN_W;
    localparam logic [MW:0] INF_MAG  = (MW+1)'((1 << EXP_W) - 1) << MAN_W;
    localparam logic [MW:0] SPAN     = INF_MAG - MIN_NORM;

    logic [MW:0] offs;
    logic        in_norm;

    always_comb begin
        offs    = {1'b0, mag_i} - MIN_NORM;
        in_norm = (offs < SPAN);
        if (in_norm) begin
            kind_o = FK_NORM;
        end else if ({1'b0, mag_i} >= INF_MAG) begin
            kind_o = FK_SPEC;
        end else if (mag_i != '0) begin
            kind_o = FK_SUB;
        end else begin
            kind_o = FK_ZERO;
        end
    end

endmodule

// File: rtl/fpw_subnorm.sv
// Renormalises a subnormal significand: shift so the leading one lands
// on the hidden position, drop it, and report the exponent decrement.
module fpw_subnorm
    import fpw_pkg::*;
#(
    parameter int SRC_MAN = HALF_MAN_W,
    parameter int DST_MAN = SINGLE_MAN_W
) (
    input  logic [SRC_MAN:0]             sig_i,
    output logic [DST_MAN-1:0]           frac_o,
    output logic [$clog2(SRC_MAN+2)-1:0] scale_o
);
    localparam int LZW = SRC_MAN + 1;
    localparam int CW  = $clog2(LZW + 1);
    localparam int GAP = DST_MAN - SRC_MAN;

    logic [CW-1:0]    lz;
    logic [DST_MAN:0] wide;

    fpw_lzc #(.WIDTH(LZW)) u_lzc (
        .val_i (sig_i),
        .cnt_o (lz)
    );

    always_comb begin
        wide    = {sig_i, {GAP{1'b0}}} << lz;
        wide    = wide ^ ((DST_MAN+1)'(1) << DST_MAN);
        frac_o  = wide[DST_MAN-1:0];
        scale_o = lz;
    end

endmodule

// File: rtl/fpw_half_to_single.sv
module fpw_half_to_single
    import fpw_pkg::*;
#(
    parameter int HE = HALF_EXP_W,
    parameter int HM = HALF_MAN_W,
    parameter int SE = SINGLE_EXP_W,
    parameter int SM = SINGLE_MAN_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic [HE+HM:0]   in_half_i,
    output logic             out_valid_o,
    output logic [SE+SM:0]   out_single_o
);
    localparam int HW     = 1 + HE + HM;
    localparam int SW     = 1 + SE + SM;
    localparam int HBIAS  = (1 << (HE - 1)) - 1;
    localparam int SBIAS  = (1 << (SE - 1)) - 1;
    localparam int BIAS_D = SBIAS - HBIAS;
    localparam int GAP    = SM - HM;
    localparam int SCW    = $clog2(HM + 2);

    typedef struct packed {
        logic          valid;
        logic [SW-1:0] data;
    } wstate_t;

    wstate_t st_d, st_q;

    logic [HW-2:0] mag;
    logic          sgn;
    logic [HE-1:0] hexp;
    logic [HM-1:0] hman;
    fkind_e        kind;
    logic [SM-1:0] sub_frac;
    logic [SCW-1:0] sub_scale;
    logic [SE-1:0] res_exp;
    logic [SM-1:0] res_man;

    assign mag  = in_half_i[HW-2:0];
    assign sgn  = in_half_i[HW-1];
    assign hexp = mag[HW-2:HM];
    assign hman = mag[HM-1:0];

    fpw_classify #(.EXP_W(HE), .MAN_W(HM)) u_cls (
        .mag_i  (mag),
        .kind_o (kind)
    );

    fpw_subnorm #(.SRC_MAN(HM), .DST_MAN(SM)) u_sub (
        .sig_i   (mag[HM:0]),
        .frac_o  (sub_frac),
        .scale_o (sub_scale)
    );

    always_comb begin
        unique case (kind)
            FK_NORM: begin
                res_exp = SE'(hexp) + SE'(BIAS_D);
                res_man = {hman, {GAP{1'b0}}};
            end
            FK_SPEC: begin
                res_exp = '1;
                res_man = {hman, {GAP{1'b0}}};
            end
            FK_SUB: begin
                res_exp = SE'(BIAS_D + 1) - SE'(sub_scale);
                res_man = sub_frac;
            end
            default: begin
                res_exp = '0;
                res_man = '0;
            end
        endcase

        st_d.valid = in_valid_i;
        st_d.data  = in_valid_i ? {sgn, res_exp, res_man} : st_q.data;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o  = st_q.valid;
    assign out_single_o = st_q.data;

endmodule

// File: rtl/fpw_half_to_single_chk.sv
module fpw_half_to_single_chk #(
    parameter int HE = 5,
    parameter int HM = 10,
    parameter int SE = 8,
    parameter int SM = 23
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           in_valid_i,
    input logic [HE+HM:0] in_half_i,
    input logic           out_valid_o,
    input logic [SE+SM:0] out_single_o
);
    localparam int GAP = SM - HM;
    localparam logic [HE+HM-1:0] H_INF = {{HE{1'b1}}, {HM{1'b0}}};

    // high when the previous cycle was outside reset
    logic armed_q;
    always_ff @(posedge clk_i) begin
        armed_q <= !rst_i;
    end

    p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        armed_q |-> (out_valid_o == $past(in_valid_i)));

    p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !$past(in_valid_i)) |-> $stable(out_single_o));

    p_sign_copy_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(in_valid_i)) |-> (out_single_o[SE+SM] == $past(in_half_i[HE+HM])));

    p_inf_map_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(in_valid_i) && ($past(in_half_i[HE+HM-1:0]) == H_INF))
        |-> (out_single_o[SE+SM-1:0] == {{SE{1'b1}}, {SM{1'b0}}}));

    p_nan_map_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(in_valid_i) && ($past(in_half_i[HE+HM-1:HM]) == '1)
         && ($past(in_half_i[HM-1:0]) != '0))
        |-> (out_single_o[SE+SM-1:0] == {{SE{1'b1}}, $past(in_half_i[HM-1:0]), {GAP{1'b0}}}));

    p_zero_map_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && $past(in_valid_i) && ($past(in_half_i[HE+HM-1:0]) == '0))
        |-> (out_single_o[SE+SM-1:0] == '0));

endmodule

bind fpw_half_to_single fpw_half_to_single_chk #(
    .HE(HE), .HM(HM), .SE(SE), .SM(SM)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .in_valid_i   (in_valid_i),
    .in_half_i    (in_half_i),
    .out_valid_o  (out_valid_o),
    .out_single_o (out_single_o)
);

// File: tb/sim_fpw_half_to_single.sv
module sim_fpw_half_to_single;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_half;
    logic        out_valid;
    logic [31:0] out_single;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpw_half_to_single u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .in_valid_i   (in_valid),
        .in_half_i    (in_half),
        .out_valid_o  (out_valid),
        .out_single_o (out_single)
    );

    // Model: locate highest set fraction bit instead of counting zeros
    function automatic logic [31:0] model(input logic [15:0] h);
        logic [4:0]  e;
        logic [9:0]  f;
        logic [7:0]  oe;
        logic [22:0] om;
        int          top;
        e = h[14:10];
        f = h[9:0];
        if (e == 5'd31) begin
            oe = 8'hFF;
            om = {f, 13'd0};
        end else if (e != 0) begin
            oe = 8'(int'(e) - 15 + 127);
            om = {f, 13'd0};
        end else if (f == 0) begin
            oe = 8'd0;
            om = 23'd0;
        end else begin
            top = 0;
            for (int b = 0; b < 10; b++) if (f[b]) top = b;
            oe = 8'(top - 24 + 127);
            om = {10'(f << (10 - top)), 13'd0};
        end
        return {h[15], oe, om};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic convert_one(input string tag, input logic [15:0] h);
        @(negedge clk);
        in_valid = 1'b1;
        in_half  = h;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, out_single, model(h));
    endtask

    task automatic t_reset();
        rst      = 1'b1;
        in_valid = 1'b1;
        in_half  = 16'h3C00;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 data in reset", out_single, 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 data after reset", out_single, 32'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b1;
        in_half  = 16'h4000;
        check("R2 no early valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid one cycle later", {31'd0, out_valid}, 32'd1);
        check("R2 data one cycle later", out_single, 32'h40000000);
        @(negedge clk);
        check("R2 valid drops", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_hold();
        convert_one("R3 setup", 16'h3C00);
        in_half = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R3 held", out_single, 32'h3F800000);
    endtask

    task automatic t_normals();
        convert_one("R4 one", 16'h3C00);
        check("R4 one const", out_single, 32'h3F800000);
        convert_one("R4 max", 16'h7BFF);
        check("R4 max const", out_single, 32'h477FE000);
        convert_one("R4 min normal", 16'h0400);
        check("R4 min normal const", out_single, 32'h38800000);
    endtask

    task automatic t_special();
        convert_one("R5 +inf", 16'h7C00);
        check("R5 +inf const", out_single, 32'h7F800000);
        convert_one("R5 -inf", 16'hFC00);
        check("R5 -inf const", out_single, 32'hFF800000);
        convert_one("R6 quiet nan", 16'h7E01);
        check("R6 quiet nan const", out_single, 32'h7FC02000);
        convert_one("R6 signalling nan", 16'h7C01);
        check("R6 signalling nan const", out_single, 32'h7F802000);
    endtask

    task automatic t_subnormal();
        convert_one("R7 smallest", 16'h0001);
        check("R7 smallest const", out_single, 32'h33800000);
        convert_one("R7 top bit", 16'h0200);
        check("R7 top bit const", out_single, 32'h38000000);
        convert_one("R7 largest", 16'h03FF);
        check("R7 largest const", out_single, 32'h387FC000);
    endtask

    task automatic t_zero_sign();
        convert_one("R8 +0", 16'h0000);
        check("R8 +0 const", out_single, 32'h00000000);
        convert_one("R8 -0", 16'h8000);
        check("R8 -0 const", out_single, 32'h80000000);
        convert_one("R9 neg normal", 16'hC000);
        check("R9 neg normal const", out_single, 32'hC0000000);
        convert_one("R9 neg subnormal", 16'h8001);
        check("R9 neg subnormal const", out_single, 32'hB3800000);
    endtask

    task automatic t_exhaustive();
        @(negedge clk);
        in_valid = 1'b1;
        in_half  = 16'h0000;
        for (int i = 1; i <= 65536; i++) begin
            @(negedge clk);
            check("R10 sweep", out_single, model(16'(i - 1)));
            if (i < 65536) in_half = 16'(i);
            else in_valid = 1'b0;
        end
    endtask

    initial begin
        in_valid = 1'b0;
        in_half  = 16'h0000;
        rst      = 1'b1;
        t_reset();
        t_latency();
        t_hold();
        t_normals();
        t_special();
        t_subnormal();
        t_zero_sign();
        t_exhaustive();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule